// File: doc/BRIEF.md
# Four-Way Interleaved Memory Dispatcher

The block takes a stream of independent single-word memory requests and spreads them over four memory banks. The two lowest address bits pick the bank, and the bank stores the word at the remaining upper bits. Each bank stays busy for a memory cycle of `MEM_CYC` bus cycles. While one bank is busy, requests for the other banks keep flowing. A stream of consecutive addresses therefore reaches one access per bus cycle. A stream that stays on one bank drops to one access per memory cycle.

The request side is a valid/ready channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the source must hold `req_valid` high and keep the address, write flag and write data unchanged. `req_ready` drops only when the target bank has not yet freed, or when a read finds the tag queue full. The response side has no back-pressure. Read data is returned in the order the reads were accepted. A small queue holds the bank number of every read still in flight. Writes never produce a response.

Top module: `ilv_mem_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_ready` is 1 and `resp_valid` is 0.
- R2: A request goes to bank `req_addr[1:0]` and is stored at `req_addr[ADDR_W-1:2]` inside that bank. A word written at address A reads back from address A, and other addresses are not disturbed.
- R3: `req_ready` is low exactly when the target bank is still busy, or when a read finds the tag queue full with no response leaving that cycle. A request to a free bank is accepted in the cycle after the preceding acceptance.
- R4: After a bank accepts a request, that bank accepts its next request no earlier than `MEM_CYC` cycles later. A stream of sequential addresses is accepted at one request per cycle.
- R5: For a read accepted on edge n, `resp_valid` is high for exactly one cycle, following edge n+`MEM_CYC`, with the read word on `resp_rdata`.
- R6: Read responses leave in the order in which the reads were accepted, even when those reads went to different banks.
- R7: An accepted write never raises `resp_valid`.
- R8: A read that follows a write to the same address returns the newly written word, even when the read is issued right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; bits [1:0] select the bank |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Read data present (one-cycle pulse) |
| resp_rdata | output | DATA_W | Read data |

## Verification
An acceptance happens on the edge that follows a low-phase sample showing `req_valid` and `req_ready` both high. The matching read response falls due exactly `MEM_CYC` edges later. The bench's monitor works from those sample points. It stores each expected word together with its due cycle and checks `resp_valid` in every cycle: it must be high with the right data when a word is due, and low in every other cycle. Acceptance cycles are taken from the driver and compared against 1-cycle spacing for cross-bank streams and `MEM_CYC` spacing for same-bank streams. The `req_ready` stall is sampled in the low phase just after a same-bank acceptance.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int BSEL_W    = 2;
  localparam int NUM_BANKS = 1 << BSEL_W;
  typedef logic [BSEL_W-1:0] bank_idx_t;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int SUB_W   = 8,
  parameter int DATA_W  = 32,
  parameter int MEM_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [SUB_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              free_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << SUB_W;
  localparam int CNT_W = $clog2(MEM_CYC + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              op_we_q;
  logic [SUB_W-1:0]  op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic [DATA_W-1:0] store [DEPTH];
  logic              fin;

  assign fin    = (cnt_q == CNT_W'(1));
  assign free_o = (cnt_q <= CNT_W'(1));
  assign done_o = done_q;
  assign rdata_o = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      done_q     <= 1'b0;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
    end else begin
      done_q <= fin && !op_we_q;
      if (start_i) begin
        cnt_q      <= CNT_W'(MEM_CYC);
        op_we_q    <= we_i;
        op_addr_q  <= addr_i;
        op_wdata_q <= wdata_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fin) begin
      if (op_we_q) store[op_addr_q] <= op_wdata_q;
      else         rdata_q <= store[op_addr_q];
    end
  end

  // R4
  bank_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> free_o);
  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MEM_CYC > 1) && start_i |=> !free_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ilv_tagq.sv
module ilv_tagq #(
  parameter int W     = 2,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]   slot [DEPTH];
  logic [PTR_W:0] wp_q, rp_q;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[PTR_W] != rp_q[PTR_W]) &&
                   (wp_q[PTR_W-1:0] == rp_q[PTR_W-1:0]);
  assign dout_o  = slot[rp_q[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) slot[wp_q[PTR_W-1:0]] <= din_i;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (!full_o || pop_i));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ilv_mem_dispatch.sv
module ilv_mem_dispatch
  import ilv_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int MEM_CYC    = 4,
  parameter int TAGQ_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata
);
  localparam int SUB_W = ADDR_W - BSEL_W;

  bank_idx_t         sel, head;
  logic [SUB_W-1:0]  sub_addr;
  logic [NUM_BANKS-1:0] bank_free, bank_done, bank_start;
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
  logic              tq_empty, tq_full, tq_push, tq_pop, tq_ok, accept;

  assign sel      = req_addr[BSEL_W-1:0];
  assign sub_addr = req_addr[ADDR_W-1:BSEL_W];
  assign tq_pop   = resp_valid;
  assign tq_ok    = req_we || !tq_full || tq_pop;
  assign req_ready = bank_free[sel] && tq_ok;
  assign accept   = req_valid && req_ready;
  assign tq_push  = accept && !req_we;

  assign resp_valid = !tq_empty && bank_done[head];
  assign resp_rdata = bank_rdata[head];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_start[b] = accept && (sel == bank_idx_t'(b));
    ilv_bank #(.SUB_W(SUB_W), .DATA_W(DATA_W), .MEM_CYC(MEM_CYC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (bank_start[b]),
      .we_i    (req_we),
      .addr_i  (sub_addr),
      .wdata_i (req_wdata),
      .free_o  (bank_free[b]),
      .done_o  (bank_done[b]),
      .rdata_o (bank_rdata[b])
    );
  end

  ilv_tagq #(.W(BSEL_W), .DEPTH(TAGQ_DEPTH)) u_tagq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (tq_push),
    .din_i   (sel),
    .pop_i   (tq_pop),
    .dout_o  (head),
    .empty_o (tq_empty),
    .full_o  (tq_full)
  );

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_start));
  // R6
  done_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_done != '0) |-> resp_valid && $onehot0(bank_done));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);
endmodule

// File: tb/ilv_mem_dispatch_test.sv
`timescale 1ns/1ps
module ilv_mem_dispatch_test;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int MEM_CYC = 4;
  localparam int NV = 16;
  // {we, addr, data}
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 10'd0, 32'h0000_00A0}, {1'b1, 10'd1, 32'h0000_00A1},
    {1'b1, 10'd2, 32'h0000_00A2}, {1'b1, 10'd3, 32'h0000_00A3},
    {1'b1, 10'd5, 32'h0000_00B5}, {1'b0, 10'd3, 32'h0},
    {1'b0, 10'd2, 32'h0},         {1'b0, 10'd1, 32'h0},
    {1'b0, 10'd0, 32'h0},         {1'b0, 10'd5, 32'h0},
    {1'b1, 10'd6, 32'h0000_00C6}, {1'b0, 10'd6, 32'h0},
    {1'b1, 10'd0, 32'h0000_00D0}, {1'b0, 10'd0, 32'h0},
    {1'b1, 10'd7, 32'h0000_00E7}, {1'b0, 10'd7, 32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, resp_valid;
  logic [DATA_W-1:0] resp_rdata;

  int checks = 0, bad = 0, cyc = 0;
  logic [DATA_W-1:0] model [1 << ADDR_W];
  logic [DATA_W-1:0] exp_data [64];
  int exp_due [64];
  logic [5:0] qh = '0, qt = '0;

  ilv_mem_dispatch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_CYC(MEM_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // monitor: R5 R6 R7 R8 response timing and data
  always @(negedge clk) begin
    if (cyc > 20000) begin
      checks++; bad++;
      $display("FAIL watchdog: actual cycle %0d expected done", cyc);
      summary();
    end
    if (rst_n) begin
      if (qh != qt && exp_due[qh] == cyc) begin
        checks++;
        if (!resp_valid || resp_rdata !== exp_data[qh]) begin
          bad++;
          $display("FAIL R5 R6 R8: actual valid=%0b data=%h expected valid=1 data=%h",
                   resp_valid, resp_rdata, exp_data[qh]);
        end
        qh = qh + 1'b1;
      end else if (resp_valid) begin
        checks++; bad++;
        $display("FAIL R7: actual resp_valid=1 expected 0 at cycle %0d", cyc);
      end
      if (req_valid && req_ready) begin
        if (req_we) model[req_addr] = req_wdata;
        else begin
          exp_data[qt] = model[req_addr];
          exp_due[qt]  = cyc + 1 + MEM_CYC;
          qt = qt + 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic we, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, output int t);
    logic ok;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); ok = req_ready;
      @(posedge clk); #1;
    end while (!ok);
    t = cyc;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  initial begin
    int t0, t1, t2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready === 1'b1, "R1 ready in reset", req_ready, 1);
    check(resp_valid === 1'b0, "R1 resp in reset", resp_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    check(resp_valid === 1'b0, "R1 resp after reset", resp_valid, 0);
    @(posedge clk); #1;

    // R2 R6 R8 vector table
    for (int i = 0; i < NV; i++) send(VEC[i][42], VEC[i][41:32], VEC[i][31:0], t0);
    idle();
    repeat (MEM_CYC + 2) @(posedge clk); #1;

    // R3 stall on busy bank, R4 spacing, R8 immediate read-after-write
    send(1'b1, 10'd0, 32'h1234_5678, t0);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 10'd0;
    @(negedge clk);
    check(req_ready === 1'b0, "R3 busy bank stalls", req_ready, 0);
    @(posedge clk); #1;
    send(1'b0, 10'd0, 32'h0, t1);
    check(t1 - t0 == MEM_CYC, "R4 same bank spacing", t1 - t0, MEM_CYC);
    send(1'b0, 10'd1, 32'h0, t2);
    check(t2 - t1 == 1, "R3 free bank next cycle", t2 - t1, 1);
    idle();
    repeat (MEM_CYC + 2) @(posedge clk); #1;

    // R4 sequential throughput: writes then reads
    send(1'b1, 10'd32, 32'hF000_0020, t0);
    for (int i = 33; i < 48; i++) send(1'b1, ADDR_W'(i), 32'hF000_0000 + i, t1);
    check(t1 - t0 == 15, "R4 sequential writes", t1 - t0, 15);
    send(1'b0, 10'd32, 32'h0, t0);
    for (int i = 33; i < 48; i++) send(1'b0, ADDR_W'(i), 32'h0, t1);
    check(t1 - t0 == 15, "R4 sequential reads", t1 - t0, 15);
    idle();
    repeat (MEM_CYC + 2) @(posedge clk); #1;

    // R4 same-bank stream
    send(1'b1, 10'd64, 32'h5500_0040, t0);
    for (int i = 1; i < 6; i++) send(1'b1, ADDR_W'(64 + 4 * i), 32'h5500_0040 + i, t1);
    check(t1 - t0 == 5 * MEM_CYC, "R4 same bank writes", t1 - t0, 5 * MEM_CYC);
    send(1'b0, 10'd64, 32'h0, t0);
    for (int i = 1; i < 6; i++) send(1'b0, ADDR_W'(64 + 4 * i), 32'h0, t1);
    check(t1 - t0 == 5 * MEM_CYC, "R4 same bank reads", t1 - t0, 5 * MEM_CYC);
    idle();

    // R7 write-only burst, no response expected
    for (int i = 0; i < 4; i++) send(1'b1, ADDR_W'(200 + i), 32'h77 + i, t0);
    idle();
    repeat (MEM_CYC + 4) @(posedge clk);
    @(negedge clk);
    check(qh == qt, "R5 all responses arrived", int'(qt - qh), 0);
    summary();
  end
endmodule